// File: doc/BRIEF.md
# SHA3/SM3 Vector Crypto Execution Unit

This unit decodes and executes a small family of 128-bit SIMD cryptographic operations. The caller supplies a 32-bit instruction word, three 128-bit source operands already read from the register file, and two feature-enable bits. The unit returns a 128-bit result, the destination register index, and two flags. One flag marks encodings that are undefined. The other marks encodings that are recognised but not executed here.

The supported operations are a three-input XOR, a bit-clear followed by XOR, an XOR followed by a rotate right, an XOR with a source rotated left by one, and the SM3 SS1 step. The first four work on two independent 64-bit lanes. The SS1 step works on the top 32-bit element only.

A valid/ready handshake sits on the input, and a single register stage holds the result until it is taken. The caller writes the result back to the destination register only when the write-enable output is high.

Top module: `vcx_unit`

## Requirements
- R1: For an instruction word with (insn & 0xFF808000) == 0xCE000000, the fields are taken as follows: op select in bits 22:21, m-source register in 20:16, a-source register in 14:10, n-source register in 9:5, destination in 4:0. Op select 0 gives n ^ m ^ a in each 64-bit lane. Lane 0 occupies result bits 63:0.
- R2: In the same class, op select 1 gives n ^ (m & ~a) in each 64-bit lane.
- R3: In the same class, op select 2 gives rotr(rotr(n[127:96],20) + m[127:96] + a[127:96], 25) in result bits 127:96. The sum is taken modulo 2^32, and result bits 95:0 are zero.
- R4: For (insn & 0xFFE00000) == 0xCE800000, each 64-bit lane gives rotr(n ^ m, k), where k is the 6-bit amount in bits 15:10. Amounts of 0 and 63 behave the same way as any other amount.
- R5: For (insn & 0xFFE0B000) == 0xCE608000 with bit 14 = 0 and bits 11:10 = 3, each 64-bit lane gives n ^ rotl(m,1).
- R6: The undefined flag is raised, with a zero result and write enable low, in three cases: op select 3 in the R1 class, bit 14 = 1 with bits 11:10 = 3 in the R5 class, and an instruction word that matches none of the three classes.
- R7: feat_i[0] enables the operations of R1, R2, R4 and R5, and feat_i[1] enables the operation of R3. A matching encoding whose feature bit is 0 raises the undefined flag, gives a zero result and keeps write enable low.
- R8: The other six encodings of the R5 class raise the unsupported flag, give a zero result and keep write enable low. The undefined and unsupported flags are never high together.
- R9: rd_o carries bits 4:0 of the accepted instruction word. Write enable is high for every defined, supported operation.
- R10: in_ready_o is high when out_ready_i is high or out_valid_o is low. An accepted word appears at the outputs on the next cycle, and the outputs hold steady while out_valid_o is high and out_ready_i is low.
- R11: An asynchronous active-low reset clears out_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Instruction and operands are valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| insn_i | input | 32 | Instruction word |
| src_n_i | input | 128 | First source operand (n) |
| src_m_i | input | 128 | Second source operand (m) |
| src_a_i | input | 128 | Third source operand (a) |
| feat_i | input | 2 | Feature enables: bit 0 three-input XOR family, bit 1 SS1 |
| out_valid_o | output | 1 | Result stage holds a result |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 128 | Operation result |
| rd_o | output | 5 | Destination register index |
| undef_o | output | 1 | Undefined instruction |
| unsup_o | output | 1 | Recognised but unsupported encoding |
| wr_en_o | output | 1 | Result must be written to the destination register |

## Verification
Every lane operation runs with random 128-bit operands, so that a crossed lane, a swapped operand or a wrong rotation direction shows up as a data mismatch. Rotate amounts of 0 and 63 check the wrap at both ends of the XOR-rotate shifter. The SS1 step runs on random elements, which tells a carry-dropping adder apart from a correct one and shows whether the low elements are cleared. Every op-select and three-register sub-encoding is sent with both features enabled and with each feature disabled, alongside unmatched words, so that the decode separates undefined, unsupported and gated cases. Random back-pressure on the output checks that results are held and kept in order.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  localparam logic [31:0] FOUR_MASK   = 32'hFF80_8000;
  localparam logic [31:0] FOUR_MATCH  = 32'hCE00_0000;
  localparam logic [31:0] XAR_MASK    = 32'hFFE0_0000;
  localparam logic [31:0] XAR_MATCH   = 32'hCE80_0000;
  localparam logic [31:0] THREE_MASK  = 32'hFFE0_B000;
  localparam logic [31:0] THREE_MATCH = 32'hCE60_8000;

  localparam int FEAT_W     = 2;
  localparam int FEAT_SHA3  = 0;
  localparam int FEAT_SM3   = 1;

  typedef enum logic [2:0] {
    OP_NONE, OP_EOR3, OP_BCAX, OP_SS1, OP_XAR, OP_RAX1
  } vcx_op_e;

  typedef struct packed {
    vcx_op_e    op;
    logic [5:0] rot;
    logic [4:0] rd;
    logic       undef;
    logic       unsup;
  } vcx_dec_t;
endpackage

// File: rtl/vcx_decode.sv
module vcx_decode
  import vcx_pkg::*;
(
  input  logic [31:0]       insn_i,
  input  logic [FEAT_W-1:0] feat_i,
  output vcx_dec_t          dec_o
);
  vcx_op_e op;
  logic    undef, unsup, need_sha3, need_sm3;

  always_comb begin
    op    = OP_NONE;
    undef = 1'b0;
    unsup = 1'b0;
    if ((insn_i & FOUR_MASK) == FOUR_MATCH) begin
      unique case (insn_i[22:21])
        2'd0:    op = OP_EOR3;
        2'd1:    op = OP_BCAX;
        2'd2:    op = OP_SS1;
        default: undef = 1'b1;
      endcase
    end else if ((insn_i & XAR_MASK) == XAR_MATCH) begin
      op = OP_XAR;
    end else if ((insn_i & THREE_MASK) == THREE_MATCH) begin
      if (insn_i[11:10] == 2'd3) begin
        if (insn_i[14]) undef = 1'b1;
        else            op    = OP_RAX1;
      end else begin
        unsup = 1'b1;
      end
    end else begin
      undef = 1'b1;
    end

    need_sha3 = (op == OP_EOR3) || (op == OP_BCAX) || (op == OP_XAR) || (op == OP_RAX1);
    need_sm3  = (op == OP_SS1);
    if ((need_sha3 && !feat_i[FEAT_SHA3]) || (need_sm3 && !feat_i[FEAT_SM3])) begin
      op    = OP_NONE;
      undef = 1'b1;
    end

    dec_o.op    = op;
    dec_o.rot   = insn_i[15:10];
    dec_o.rd    = insn_i[4:0];
    dec_o.undef = undef;
    dec_o.unsup = unsup;
  end
endmodule

// File: rtl/vcx_lane.sv
module vcx_lane
  import vcx_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int ROT_W  = $clog2(LANE_W)
) (
  input  vcx_op_e           op_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [LANE_W-1:0] n_i,
  input  logic [LANE_W-1:0] m_i,
  input  logic [LANE_W-1:0] a_i,
  output logic [LANE_W-1:0] y_o
);
  logic [2*LANE_W-1:0] dbl;
  logic [LANE_W-1:0]   nm;

  always_comb begin
    nm  = n_i ^ m_i;
    // doubled word makes rotr valid for every amount including 0
    dbl = {nm, nm} >> rot_i;
    unique case (op_i)
      OP_EOR3: y_o = n_i ^ m_i ^ a_i;
      OP_BCAX: y_o = n_i ^ (m_i & ~a_i);
      OP_XAR:  y_o = dbl[LANE_W-1:0];
      OP_RAX1: y_o = n_i ^ {m_i[LANE_W-2:0], m_i[LANE_W-1]};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/vcx_ss1.sv
module vcx_ss1 #(
  parameter int EL_W = 32
) (
  input  logic [EL_W-1:0] n_i,
  input  logic [EL_W-1:0] m_i,
  input  logic [EL_W-1:0] a_i,
  output logic [EL_W-1:0] y_o
);
  logic [EL_W-1:0] t, s;

  always_comb begin
    t   = {n_i[19:0], n_i[EL_W-1:20]};
    s   = t + m_i + a_i;
    y_o = {s[24:0], s[EL_W-1:25]};
  end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit
  import vcx_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 64,
  parameter int EL_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       insn_i,
  input  logic [DATA_W-1:0] src_n_i,
  input  logic [DATA_W-1:0] src_m_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [FEAT_W-1:0] feat_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] result_o,
  output logic [4:0]        rd_o,
  output logic              undef_o,
  output logic              unsup_o,
  output logic              wr_en_o
);
  localparam int N_LANES = DATA_W / LANE_W;
  localparam int ROT_W   = $clog2(LANE_W);
  localparam int TOP_LO  = DATA_W - EL_W;

  vcx_dec_t          dec;
  logic [DATA_W-1:0] lane_res, res_d;
  logic [EL_W-1:0]   ss1_res;

  vcx_decode u_dec (.insn_i(insn_i), .feat_i(feat_i), .dec_o(dec));

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    vcx_lane #(.LANE_W(LANE_W), .ROT_W(ROT_W)) u_lane (
      .op_i (dec.op),
      .rot_i(dec.rot[ROT_W-1:0]),
      .n_i  (src_n_i[l*LANE_W +: LANE_W]),
      .m_i  (src_m_i[l*LANE_W +: LANE_W]),
      .a_i  (src_a_i[l*LANE_W +: LANE_W]),
      .y_o  (lane_res[l*LANE_W +: LANE_W])
    );
  end

  vcx_ss1 #(.EL_W(EL_W)) u_ss1 (
    .n_i(src_n_i[DATA_W-1:TOP_LO]),
    .m_i(src_m_i[DATA_W-1:TOP_LO]),
    .a_i(src_a_i[DATA_W-1:TOP_LO]),
    .y_o(ss1_res)
  );

  always_comb begin
    if (dec.undef || dec.unsup) res_d = '0;
    else if (dec.op == OP_SS1)  res_d = {ss1_res, {TOP_LO{1'b0}}};
    else                        res_d = lane_res;
  end

  logic wr_q;
  assign in_ready_o = out_ready_i || !out_valid_o;
  assign wr_en_o    = out_valid_o && wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      rd_o        <= '0;
      undef_o     <= 1'b0;
      unsup_o     <= 1'b0;
      wr_q        <= 1'b0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        rd_o     <= dec.rd;
        undef_o  <= dec.undef;
        unsup_o  <= dec.unsup;
        wr_q     <= !dec.undef && !dec.unsup;
      end
    end
  end
endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [31:0]       insn_i,
  input logic [1:0]        feat_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] result_o,
  input logic              undef_o,
  input logic              unsup_o,
  input logic              wr_en_o
);
  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o));

  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(undef_o && unsup_o));

  p_flag_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (undef_o || unsup_o) |-> result_o == '0 && !wr_en_o);

  p_ss1_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && insn_i[31:23] == 9'b1100_1110_0 && !insn_i[15]
      && insn_i[22:21] == 2'd2 && feat_i[1]
    |=> result_o[DATA_W-33:0] == '0 && wr_en_o);
endmodule

bind vcx_unit vcx_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .insn_i(insn_i), .feat_i(feat_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .result_o(result_o), .undef_o(undef_o), .unsup_o(unsup_o), .wr_en_o(wr_en_o)
);

// File: tb/vcx_unit_bench.sv
module vcx_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  insn = '0;
  logic [127:0] sn = '0, sm = '0, sa = '0;
  logic [1:0]   feat = 2'b11;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] result;
  logic [4:0]   rd;
  logic         undef, unsup, wr_en;

  int checks = 0;
  int failures = 0;
  bit stall = 1'b0;

  logic [135:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  vcx_unit u_vcx_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .insn_i(insn), .src_n_i(sn), .src_m_i(sm), .src_a_i(sa), .feat_i(feat),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .result_o(result), .rd_o(rd),
    .undef_o(undef), .unsup_o(unsup), .wr_en_o(wr_en)
  );

  function automatic logic [63:0] ror64(input logic [63:0] x, input int k);
    if (k == 0) return x;
    return (x >> k) | (x << (64 - k));
  endfunction

  function automatic logic [31:0] ror32(input logic [31:0] x, input int k);
    return (x >> k) | (x << (32 - k));
  endfunction

  // packed: {result, rd, undef, unsup, wr}
  function automatic logic [135:0] model(input logic [31:0] w, input logic [127:0] n, m, a,
                                         input logic [1:0] f, output string tag);
    logic [127:0] r = '0;
    bit u = 0, s = 0;
    logic [31:0] e;
    tag = "R6";
    if (w[31:23] == 9'h19C && !w[15]) begin
      case (w[22:21])
        2'd0: begin tag = "R1/R7/R9"; u = !f[0];
          for (int l = 0; l < 2; l++) r[l*64 +: 64] = n[l*64 +: 64] ^ m[l*64 +: 64] ^ a[l*64 +: 64]; end
        2'd1: begin tag = "R2/R7/R9"; u = !f[0];
          for (int l = 0; l < 2; l++) r[l*64 +: 64] = n[l*64 +: 64] ^ (m[l*64 +: 64] & ~a[l*64 +: 64]); end
        2'd2: begin tag = "R3/R7/R9"; u = !f[1];
          e = ror32(ror32(n[127:96], 20) + m[127:96] + a[127:96], 25); r = {e, 96'd0}; end
        default: begin tag = "R6"; u = 1; end
      endcase
    end else if (w[31:21] == 11'h674) begin
      tag = "R4/R7/R9"; u = !f[0];
      for (int l = 0; l < 2; l++) r[l*64 +: 64] = ror64(n[l*64 +: 64] ^ m[l*64 +: 64], int'(w[15:10]));
    end else if (w[31:21] == 11'h673 && w[15] && !w[13] && !w[12]) begin
      if (w[11:10] == 2'd3 && !w[14]) begin
        tag = "R5/R7/R9"; u = !f[0];
        for (int l = 0; l < 2; l++) r[l*64 +: 64] = n[l*64 +: 64] ^ {m[l*64 +: 63], m[l*64 + 63]};
      end else if (w[11:10] == 2'd3) begin
        tag = "R6"; u = 1;
      end else begin
        tag = "R8"; s = 1;
      end
    end else begin
      u = 1;
    end
    if (u || s) r = '0;
    return {r, w[4:0], u, s, !(u || s)};
  endfunction

  task automatic send(input logic [31:0] w, input logic [127:0] n, m, a, input logic [1:0] f);
    string t;
    logic [135:0] e;
    e = model(w, n, m, a, f, t);
    @(negedge clk); #1;
    in_valid = 1'b1; insn = w; sn = n; sm = m; sa = a; feat = f;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] four(input int op0);
    return 32'hCE00_0000 | (op0 << 21) | (($urandom & 31) << 16) | (($urandom & 31) << 10)
         | (($urandom & 31) << 5) | ($urandom & 31);
  endfunction

  function automatic logic [31:0] xar(input int k);
    return 32'hCE80_0000 | (($urandom & 31) << 16) | ((k & 63) << 10)
         | (($urandom & 31) << 5) | ($urandom & 31);
  endfunction

  function automatic logic [31:0] three(input int o, input int opc);
    return 32'hCE60_8000 | (o << 14) | (opc << 10) | (($urandom & 31) << 16)
         | (($urandom & 31) << 5) | ($urandom & 31);
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      bit r;
      logic [135:0] e;
      string t;
      @(negedge clk);
      if (rst_n) begin
        r = !stall && ($urandom % 4 != 0);
        if (out_valid && r) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected result", "none");
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({result, rd, undef, unsup, wr_en} === e, t,
                  $sformatf("%h", {result, rd, undef, unsup, wr_en}), $sformatf("%h", e));
          end
        end
        out_ready = r;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11", $sformatf("%b", out_valid), "0");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11",
          $sformatf("%b%b", out_valid, in_ready), "01");

    for (int i = 0; i < 20; i++) send(four(0), rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 20; i++) send(four(1), rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 20; i++) send(four(2), rnd128(), rnd128(), rnd128(), 2'b11);
    send(four(2), {32'hFFFF_FFFF, 96'd1}, {32'hFFFF_FFFF, 96'd2}, {32'h0000_0002, 96'd3}, 2'b11);
    send(xar(0), rnd128(), rnd128(), rnd128(), 2'b11);
    send(xar(63), rnd128(), rnd128(), rnd128(), 2'b11);
    send(xar(1), rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 20; i++) send(xar($urandom & 63), rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 20; i++) send(three(0, 3), rnd128(), rnd128(), rnd128(), 2'b11);
    // R6 unallocated and R8 unsupported sub-encodings
    send(four(3), rnd128(), rnd128(), rnd128(), 2'b11);
    for (int o = 0; o < 2; o++)
      for (int c = 0; c < 4; c++) send(three(o, c), rnd128(), rnd128(), rnd128(), 2'b11);
    // R7 feature gating
    send(four(0), rnd128(), rnd128(), rnd128(), 2'b10);
    send(four(1), rnd128(), rnd128(), rnd128(), 2'b10);
    send(xar(5), rnd128(), rnd128(), rnd128(), 2'b10);
    send(three(0, 3), rnd128(), rnd128(), rnd128(), 2'b10);
    send(four(2), rnd128(), rnd128(), rnd128(), 2'b01);
    send(four(2), rnd128(), rnd128(), rnd128(), 2'b10);
    send(four(0), rnd128(), rnd128(), rnd128(), 2'b01);
    send(three(1, 0), rnd128(), rnd128(), rnd128(), 2'b00);
    // R6 no class match
    send(32'h0000_0000, rnd128(), rnd128(), rnd128(), 2'b11);
    send(32'hFFFF_FFFF, rnd128(), rnd128(), rnd128(), 2'b11);
    send(32'hCE00_8000, rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 20; i++) send($urandom, rnd128(), rnd128(), rnd128(), 2'b11);
    for (int i = 0; i < 40; i++) begin
      int k = $urandom % 5;
      if (k == 0)      send(four($urandom & 3), rnd128(), rnd128(), rnd128(), 2'($urandom));
      else if (k == 1) send(xar($urandom), rnd128(), rnd128(), rnd128(), 2'($urandom));
      else if (k == 2) send(three($urandom & 1, $urandom & 3), rnd128(), rnd128(), rnd128(), 2'($urandom));
      else             send(four($urandom % 3), rnd128(), rnd128(), rnd128(), 2'b11);
    end

    while (exp_q.size() != 0) @(negedge clk);
    stall = 1'b1;
    repeat (2) @(negedge clk);
    send(four(0), rnd128(), rnd128(), rnd128(), 2'b11);
    @(negedge clk); #1;
    held = result;
    check(out_valid === 1'b1 && in_ready === 1'b0, "R10",
          $sformatf("%b%b", out_valid, in_ready), "10");
    @(negedge clk); #1;
    check(out_valid === 1'b1 && result === held, "R10",
          $sformatf("%b %h", out_valid, result), $sformatf("1 %h", held));
    rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R11", $sformatf("%b", out_valid), "0");
    exp_q.delete();
    tag_q.delete();

    summary();
    $finish;
  end
endmodule